// File: doc/BRIEF.md
# Memory ECC Error Capture Registers

This block sits beside a memory controller that guards each access with two 32-bit words, each protected by its own 7-bit check code. On every memory read the controller presents, for both the upper and the lower word, the check bits that came out of memory, the syndrome its checker computed and a flag telling a single-bit error from a double-bit one. The block keeps the latest of these in a 32-bit syndrome register. That register stops following reads once an error has been recorded, so it keeps the picture of the failing access.

When the controller reports a failed transaction, the block records its 27-bit address in a 32-bit error address register. It also records which master issued it (processor or DMA), its direction and its cause (an ECC error, or a timeout or overrun). The valid bit of that register drives a bus-error interrupt. Software reads either register through a one-bit select. A write strobe aimed at a register wipes that register to zero. The strobe carries no data, because the written value would never matter.

Top module: `ecc_err_capture`

## Requirements
- R1: While `rst` is high at a clock edge, both registers read as zero after that edge and `bus_err_irq` is low.
- R2: An error event (`err_stb`) arriving while the address register is not valid loads it as follows: bit 31 = 1, bit 30 = `err_cpu` (1 processor, 0 DMA), bit 29 = `err_write` (1 write, 0 read), bit 28 = `err_ecc` (1 ECC error, 0 timeout/overrun), bit 27 = 0, bits 26:0 = `err_addr`.
- R3: `bus_err_irq` is high exactly when bit 31 of the address register is set.
- R4: An error event arriving while the address register is already valid changes nothing. The first error is kept.
- R5: A write strobe with `reg_sel` = 0 clears the whole address register and the interrupt, even when an error event arrives in the same cycle. The syndrome register is left unchanged.
- R6: The syndrome register layout is as follows. The upper word uses bit 31 as valid, bits 30:24 for the check bits, bit 23 for the single flag (1 single, 0 double) and bits 22:16 for the syndrome. The lower word uses bit 15 as valid, bits 14:8 for the check bits, bit 7 for the single flag and bits 6:0 for the syndrome.
- R7: Each half's valid bit equals 1 exactly when that half's captured syndrome is nonzero.
- R8: While the address register is not valid, every read strobe (`rd_stb`) reloads both syndrome halves. This includes the read strobe that comes with an error event. Without `rd_stb` the register holds its value.
- R9: While the address register is valid, read strobes leave the syndrome register unchanged.
- R10: A write strobe with `reg_sel` = 1 clears the whole syndrome register, even when a read strobe arrives in the same cycle. The address register is left unchanged.
- R11: `reg_rdata` shows the address register when `reg_sel` = 0 and the syndrome register when `reg_sel` = 1, combinationally. Reading has no side effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_stb | input | 1 | A memory read completed this cycle |
| hi_chk | input | 7 | Stored check bits, upper word |
| hi_syn | input | 7 | Computed syndrome, upper word |
| hi_single | input | 1 | Upper word error is single-bit (1) or double-bit (0) |
| lo_chk | input | 7 | Stored check bits, lower word |
| lo_syn | input | 7 | Computed syndrome, lower word |
| lo_single | input | 1 | Lower word error is single-bit (1) or double-bit (0) |
| err_stb | input | 1 | The current transaction failed |
| err_addr | input | 27 | Address of the failing transaction |
| err_cpu | input | 1 | Processor (1) or DMA (0) master |
| err_write | input | 1 | Write (1) or read (0) |
| err_ecc | input | 1 | ECC error (1) or timeout/overrun (0) |
| reg_sel | input | 1 | Register select: 0 address, 1 syndrome |
| reg_we | input | 1 | Write strobe: clears the selected register |
| reg_rdata | output | 32 | Read data of the selected register |
| bus_err_irq | output | 1 | Bus-error interrupt |

## Verification
The bench builds the block with its default widths: a 27-bit address and 7-bit check and syndrome fields. At these widths every syndrome value of both halves can be swept, and each of the 27 address bits can be walked together with all eight master/direction/cause combinations. The expected register words are packed arithmetically from the field positions in the requirements. Every capture in the walk is followed by a blocked second error, frozen reads and both clears. Same-cycle collisions between a clear and new status are covered for each register.

// File: rtl/ecc_err_pkg.sv
package ecc_err_pkg;

  // Register selector on the software port
  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_SYN  = 1'b1
  } reg_sel_e;

  // Attributes of a failing transaction, packed in register bit order
  typedef struct packed {
    logic cpu;   // 1: processor master, 0: DMA
    logic wr;    // 1: write, 0: read
    logic ecc;   // 1: ECC error, 0: timeout or overrun
  } err_attr_t;

  localparam int ATTR_W = $bits(err_attr_t);

endpackage

// File: rtl/ecc_err_addr_reg.sv
module ecc_err_addr_reg
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              err_stb,
  input  logic [ADDR_W-1:0] err_addr,
  input  err_attr_t         attr,
  output logic [REG_W-1:0]  q,
  output logic              valid_o,
  output logic              irq_o
);

  localparam int PAD_W = REG_W - 1 - ATTR_W - ADDR_W;

  logic              vld_q;
  err_attr_t         attr_q;
  logic [ADDR_W-1:0] addr_q;
  logic              irq_q;
  logic              take;

  // first error wins; later ones are dropped until software clears
  assign take = err_stb && !vld_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld_q  <= 1'b0;
      attr_q <= '0;
      addr_q <= '0;
    end else if (take) begin
      vld_q  <= 1'b1;
      attr_q <= attr;
      addr_q <= err_addr;
    end
  end

  // interrupt kept in its own flop so the output is registered
  always_ff @(posedge clk) begin
    if (rst || clr) irq_q <= 1'b0;
    else if (err_stb) irq_q <= 1'b1;
  end

  assign q       = {vld_q, attr_q, {PAD_W{1'b0}}, addr_q};
  assign valid_o = vld_q;
  assign irq_o   = irq_q;

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (err_stb && !vld_q && !clr) |=>
      (vld_q && addr_q == $past(err_addr) && attr_q == $past(attr)));

  a_r4_first_kept: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !clr) |=> (vld_q && $stable(addr_q) && $stable(attr_q)));

  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0 && !irq_o));

  a_r3_irq_tracks_valid: assert property (@(posedge clk) disable iff (rst)
    irq_o == q[REG_W-1]);

endmodule

// File: rtl/ecc_syn_half.sv
module ecc_syn_half #(
  parameter int CHK_W = 7,
  parameter int SYN_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             ld,
  input  logic             freeze,
  input  logic [CHK_W-1:0] chk,
  input  logic             single,
  input  logic [SYN_W-1:0] syn,
  output logic [CHK_W+SYN_W+1:0] q
);

  logic             vld_q;
  logic [CHK_W-1:0] chk_q;
  logic             sng_q;
  logic [SYN_W-1:0] syn_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld_q <= 1'b0;
      chk_q <= '0;
      sng_q <= 1'b0;
      syn_q <= '0;
    end else if (ld && !freeze) begin
      vld_q <= |syn;
      chk_q <= chk;
      sng_q <= single;
      syn_q <= syn;
    end
  end

  assign q = {vld_q, chk_q, sng_q, syn_q};

  a_r8_reload: assert property (@(posedge clk) disable iff (rst)
    (ld && !freeze && !clr) |=>
      (chk_q == $past(chk) && syn_q == $past(syn) && sng_q == $past(single)));

  a_r9_frozen: assert property (@(posedge clk) disable iff (rst)
    (freeze && !clr) |=> $stable(q));

  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));

  a_r7_half_valid: assert property (@(posedge clk) disable iff (rst)
    vld_q == (syn_q != '0));

endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_err_pkg::*;
#(
  parameter int ADDR_W = 27,
  parameter int CHK_W  = 7,
  parameter int SYN_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic [CHK_W-1:0]  hi_chk,
  input  logic [SYN_W-1:0]  hi_syn,
  input  logic              hi_single,
  input  logic [CHK_W-1:0]  lo_chk,
  input  logic [SYN_W-1:0]  lo_syn,
  input  logic              lo_single,
  input  logic              err_stb,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              err_cpu,
  input  logic              err_write,
  input  logic              err_ecc,
  input  logic              reg_sel,
  input  logic              reg_we,
  output logic [2*(CHK_W+SYN_W+2)-1:0] reg_rdata,
  output logic              bus_err_irq
);

  localparam int HALF_W = CHK_W + SYN_W + 2;
  localparam int REG_W  = 2 * HALF_W;
  localparam int N_HALF = 2;

  logic      clr_addr, clr_syn;
  logic      addr_vld;
  err_attr_t attr;
  logic [REG_W-1:0] addr_word;
  logic [REG_W-1:0] syn_word;

  logic [CHK_W-1:0] chk_a [N_HALF];
  logic [SYN_W-1:0] syn_a [N_HALF];
  logic             sng_a [N_HALF];

  assign clr_addr = reg_we && (reg_sel_e'(reg_sel) == SEL_ADDR);
  assign clr_syn  = reg_we && (reg_sel_e'(reg_sel) == SEL_SYN);

  assign attr = '{cpu: err_cpu, wr: err_write, ecc: err_ecc};

  // index 0 is the lower word, index 1 the upper word
  assign chk_a[0] = lo_chk;
  assign syn_a[0] = lo_syn;
  assign sng_a[0] = lo_single;
  assign chk_a[1] = hi_chk;
  assign syn_a[1] = hi_syn;
  assign sng_a[1] = hi_single;

  ecc_err_addr_reg #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W)
  ) u_addr (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr_addr),
    .err_stb  (err_stb),
    .err_addr (err_addr),
    .attr     (attr),
    .q        (addr_word),
    .valid_o  (addr_vld),
    .irq_o    (bus_err_irq)
  );

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    ecc_syn_half #(
      .CHK_W (CHK_W),
      .SYN_W (SYN_W)
    ) u_half (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr_syn),
      .ld     (rd_stb),
      .freeze (addr_vld),
      .chk    (chk_a[h]),
      .single (sng_a[h]),
      .syn    (syn_a[h]),
      .q      (syn_word[h*HALF_W +: HALF_W])
    );
  end

  always_comb begin
    if (reg_sel_e'(reg_sel) == SEL_SYN) reg_rdata = syn_word;
    else                                reg_rdata = addr_word;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (addr_word == '0 && syn_word == '0 && !bus_err_irq));

  a_r5_syn_untouched: assert property (@(posedge clk) disable iff (rst)
    (clr_addr && !rd_stb) |=> $stable(syn_word));

  a_r10_addr_untouched: assert property (@(posedge clk) disable iff (rst)
    (clr_syn && !err_stb) |=> $stable(addr_word));

endmodule

// File: tb/sim_ecc_err_capture.sv
`timescale 1ns/1ps
module sim_ecc_err_capture;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd_stb = 1'b0;
  logic [6:0]  hi_chk = '0, hi_syn = '0, lo_chk = '0, lo_syn = '0;
  logic        hi_single = 1'b0, lo_single = 1'b0;
  logic        err_stb = 1'b0;
  logic [26:0] err_addr = '0;
  logic        err_cpu = 1'b0, err_write = 1'b0, err_ecc = 1'b0;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        bus_err_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ecc_err_capture u0 (
    .clk(clk), .rst(rst), .rd_stb(rd_stb),
    .hi_chk(hi_chk), .hi_syn(hi_syn), .hi_single(hi_single),
    .lo_chk(lo_chk), .lo_syn(lo_syn), .lo_single(lo_single),
    .err_stb(err_stb), .err_addr(err_addr),
    .err_cpu(err_cpu), .err_write(err_write), .err_ecc(err_ecc),
    .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .bus_err_irq(bus_err_irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
    end
  endtask

  // expected syndrome word from the field positions of R6 and R7
  function automatic logic [31:0] exp_syn(input logic [6:0] hc, input logic hg, input logic [6:0] hs,
                                          input logic [6:0] lc, input logic lg, input logic [6:0] ls);
    return {(hs != 0), hc, hg, hs, (ls != 0), lc, lg, ls};
  endfunction

  // expected address word from R2
  function automatic logic [31:0] exp_addr(input logic [2:0] at, input logic [26:0] a);
    return {1'b1, at[2], at[1], at[0], 1'b0, a};
  endfunction

  task automatic set_status(input logic [6:0] hc, input logic hg, input logic [6:0] hs,
                            input logic [6:0] lc, input logic lg, input logic [6:0] ls);
    hi_chk = hc; hi_single = hg; hi_syn = hs;
    lo_chk = lc; lo_single = lg; lo_syn = ls;
  endtask

  // one clock: inputs set at a falling edge, strobes dropped at the next one
  task automatic step();
    @(negedge clk);
    rd_stb = 1'b0; err_stb = 1'b0; reg_we = 1'b0;
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    reg_sel = sel;
    #0.2;
    v = reg_rdata;
  endtask

  initial begin
    logic [31:0] v, v2, es, es2, ea;
    logic [6:0] hc, hs, lc, ls;
    logic [26:0] a;
    logic [2:0] at;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    rd(1'b0, v); check("R1 address reg after reset", v, 32'h0);
    rd(1'b1, v); check("R1 syndrome reg after reset", v, 32'h0);
    check("R1 irq after reset", {31'h0, bus_err_irq}, 32'h0);

    // R6 R7 R8: sweep every syndrome value in both halves
    for (int s = 0; s < 128; s++) begin
      hs = 7'(s); ls = 7'((s * 5 + 3) % 128);
      hc = 7'(s) ^ 7'h55; lc = ~7'(s);
      set_status(hc, s[0], hs, lc, s[1], ls);
      rd_stb = 1'b1;
      step();
      rd(1'b1, v);
      check($sformatf("R6/R7/R8 sweep s=%0d", s), v, exp_syn(hc, s[0], hs, lc, s[1], ls));
    end
    rd(1'b0, v); check("R8 reads alone leave address reg clear", v, 32'h0);

    // R8: no strobe, no load
    rd(1'b1, es);
    set_status(7'h11, 1'b1, 7'h22, 7'h33, 1'b0, 7'h44);
    step();
    rd(1'b1, v); check("R8 holds without rd_stb", v, es);

    // R2 R3 R4 R5 R9 R10: walk address bits with all attribute combinations
    for (int b = 0; b < 27; b++) begin
      a  = (27'h1 << b) | 27'(b * 37);
      at = 3'(b);
      hc = 7'(b + 9); hs = 7'(b * 3); lc = 7'(b ^ 7'h2a); ls = 7'(127 - b);
      set_status(hc, at[1], hs, lc, at[0], ls);
      err_addr = a; {err_cpu, err_write, err_ecc} = at;
      err_stb = 1'b1; rd_stb = 1'b1;
      step();
      ea = exp_addr(at, a);
      es = exp_syn(hc, at[1], hs, lc, at[0], ls);
      rd(1'b0, v); check($sformatf("R2 capture bit %0d", b), v, ea);
      check($sformatf("R3 irq raised bit %0d", b), {31'h0, bus_err_irq}, 32'h1);
      rd(1'b1, v); check($sformatf("R8 syndrome with error bit %0d", b), v, es);

      set_status(~hc, ~at[1], ~hs, ~lc, ~at[0], ~ls);
      err_addr = ~a; {err_cpu, err_write, err_ecc} = ~at;
      err_stb = 1'b1; rd_stb = 1'b1;
      step();
      rd(1'b0, v); check($sformatf("R4 second error ignored bit %0d", b), v, ea);
      rd(1'b1, v); check($sformatf("R9 syndrome frozen bit %0d", b), v, es);

      reg_sel = 1'b0; reg_we = 1'b1;
      step();
      rd(1'b0, v); check($sformatf("R5 address cleared bit %0d", b), v, 32'h0);
      check($sformatf("R3 irq dropped bit %0d", b), {31'h0, bus_err_irq}, 32'h0);
      rd(1'b1, v); check($sformatf("R5 syndrome kept bit %0d", b), v, es);

      reg_sel = 1'b1; reg_we = 1'b1;
      step();
      rd(1'b1, v); check($sformatf("R10 syndrome cleared bit %0d", b), v, 32'h0);
      rd(1'b0, v); check($sformatf("R10 address kept bit %0d", b), v, 32'h0);
    end

    // R5: clear beats a same-cycle error event
    set_status(7'h05, 1'b1, 7'h06, 7'h07, 1'b0, 7'h00);
    err_addr = 27'h5a5a5a5; {err_cpu, err_write, err_ecc} = 3'b101;
    err_stb = 1'b1; rd_stb = 1'b1; reg_sel = 1'b0; reg_we = 1'b1;
    step();
    rd(1'b0, v); check("R5 clear wins over error", v, 32'h0);
    check("R5 irq stays low on collision", {31'h0, bus_err_irq}, 32'h0);
    rd(1'b1, v); check("R8 read in collision cycle loads", v, exp_syn(7'h05, 1'b1, 7'h06, 7'h07, 1'b0, 7'h00));

    // R10: clear beats a same-cycle read
    set_status(7'h7f, 1'b1, 7'h7f, 7'h7f, 1'b1, 7'h7f);
    rd_stb = 1'b1; reg_sel = 1'b1; reg_we = 1'b1;
    step();
    rd(1'b1, v); check("R10 clear wins over read", v, 32'h0);

    // R11: select and side-effect-free reads
    set_status(7'h12, 1'b0, 7'h34, 7'h56, 1'b1, 7'h78 & 7'h7f);
    err_addr = 27'h0abcdef; {err_cpu, err_write, err_ecc} = 3'b011;
    err_stb = 1'b1; rd_stb = 1'b1;
    step();
    ea = exp_addr(3'b011, 27'h0abcdef);
    es2 = exp_syn(7'h12, 1'b0, 7'h34, 7'h56, 1'b1, 7'h78 & 7'h7f);
    rd(1'b0, v);  check("R11 select address", v, ea);
    rd(1'b1, v2); check("R11 select syndrome", v2, es2);
    step(); step();
    rd(1'b0, v);  check("R11 address unchanged by reads", v, ea);
    rd(1'b1, v2); check("R11 syndrome unchanged by reads", v2, es2);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule